// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block lets an outside master borrow the shared external memory bus. The master pulls an active-low request pin low. The controller passes that pin through a synchronizer and waits for any local bus transfer that is still running to finish. It then stops driving the bus pins, and only after that does it pull the active-low acknowledge low. From that point the outside master owns the pins. When the master lets the request pin go high, the controller drives the pins again after a bounded number of cycles, and only then raises the acknowledge.

The signals that are released together are the chip selects, byte lanes, 32-bit data, word address and the three shared strobes. They all follow the one `bus_oe` output. A `grant_block` output stays high from the moment a request is accepted until the acknowledge has returned high, so the local bus controller starts no new transfer in that window. A `hold_disable` input stops new requests from being granted for as long as it is set. An `early_rel` output pulses for one cycle when the outside master withdraws its request too early.

Top module: `bus_hold_ctrl`

In the requirements, E1 is the first rising clock edge at which a change on `hold_req_n` is sampled. All numbers are for the default parameters: a 2-stage synchronizer, a float delay of at least 2 cycles, a redrive delay of 4 cycles and an acknowledge lag of 1 cycle.

## Requirements
- R1: While reset is low and right after it, `bus_oe`=1, `hold_ack_n`=1, `grant_block`=0 and `early_rel`=0.
- R2: With `xfer_busy`=0, `bus_oe` falls at edge E1+3 after `hold_req_n` goes low. This is never earlier than 2 cycles after the request.
- R3: While `xfer_busy`=1 the bus is not floated. `bus_oe` falls at the first edge that samples `xfer_busy`=0, or at E1+3 if that is later.
- R4: `hold_ack_n` falls exactly one edge after `bus_oe` falls, and never while the bus is still driven.
- R5: `grant_block` rises at E1+2 after the request and stays high while the bus is floated or acknowledged. It falls at the same edge as the acknowledge rises. This covers a local transfer that starts in the same cycle the request is accepted.
- R6: After `hold_req_n` goes high, `bus_oe` rises at E1+4, which lies in the window of 2 to 7 cycles. `hold_ack_n` rises one edge later.
- R7: While `hold_disable`=1, a pending request is never granted, and all outputs keep their idle values for as long as it stays set.
- R8: If `hold_disable` is cleared while `hold_req_n` is held low, `grant_block` rises at the first edge that samples the cleared bit. The bus floats one edge later.
- R9: If the request is withdrawn so that it is sampled high at or before the first edge after `hold_ack_n` fell, `early_rel` is high for exactly one cycle, starting at E1+2 of that withdrawal. A withdrawal made while a transfer is still pending gives the same pulse, and the bus is never floated.
- R10: A withdrawal that is first sampled at the second edge after `hold_ack_n` fell, or later, gives no `early_rel` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset (asynchronous assert) |
| hold_req_n | input | 1 | Asynchronous active-low request from the outside master |
| hold_disable | input | 1 | 1 = no new request is granted |
| xfer_busy | input | 1 | 1 = a local bus transfer is in progress |
| hold_ack_n | output | 1 | Active-low acknowledge to the outside master |
| bus_oe | output | 1 | 1 = local side drives the bus pins, 0 = pins floated |
| grant_block | output | 1 | 1 = the local controller must not start a transfer |
| early_rel | output | 1 | One-cycle pulse on a premature request withdrawal |

## Verification
Two events can land in the same cycle: the request being accepted, and the local bus controller starting a transfer. The bench raises `xfer_busy` in exactly the cycle when the synchronized request is first seen, which is before `grant_block` can react. It then checks that the float waits for the first edge that samples `xfer_busy` low, not for the usual edge E1+3. A second coincidence is a withdrawal exactly in the acknowledge cycle. The bench compares it against a withdrawal one cycle later, and the scoreboard expects an `early_rel` pulse only in the first case.

// File: rtl/hold_pkg.sv
package hold_pkg;

  typedef enum logic [2:0] {
    HS_IDLE      = 3'd0,
    HS_WAIT_DONE = 3'd1,
    HS_FLOAT     = 3'd2,
    HS_GRANTED   = 3'd3,
    HS_REDRIVE   = 3'd4,
    HS_RELEASE   = 3'd5
  } hold_state_e;

  // Extra wait cycles in WAIT_DONE beyond what synchronizer + FSM already give.
  function automatic int float_extra(input int min_float, input int sync_stages);
    return (min_float > sync_stages + 2) ? (min_float - sync_stages - 2) : 0;
  endfunction

  // Number of cycles the FSM stays in REDRIVE (at least one).
  function automatic int redrive_span(input int redrive_cyc, input int sync_stages);
    return (redrive_cyc - sync_stages > 1) ? (redrive_cyc - sync_stages) : 1;
  endfunction

  function automatic int ack_span(input int ack_lag);
    return (ack_lag < 1) ? 1 : ack_lag;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Local side owns the pins in these states.
  function automatic logic drives_bus(input hold_state_e s);
    return (s == HS_IDLE) || (s == HS_WAIT_DONE) || (s == HS_RELEASE);
  endfunction

  // Acknowledge is asserted in these states.
  function automatic logic ack_active(input hold_state_e s);
    return (s == HS_GRANTED) || (s == HS_REDRIVE) || (s == HS_RELEASE);
  endfunction

endpackage

// File: rtl/hold_req_sync.sv
module hold_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_async,
  output logic req_o
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '1;
    else        stg_q <= {stg_q[N-2:0], req_n_async};
  end

  assign req_o = ~stg_q[N-1];
endmodule

// File: rtl/hold_dly_cnt.sv
module hold_dly_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (dec && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import hold_pkg::*;
#(
  parameter int W           = 2,
  parameter int FLOAT_EXTRA = 0,
  parameter int REDRIVE_LEN = 2,
  parameter int ACK_LEN     = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic         req_disable,
  input  logic         xfer_busy,
  input  logic         cnt_zero,
  output hold_state_e  state,
  output logic         cnt_load,
  output logic [W-1:0] cnt_val,
  output logic         cnt_dec,
  output logic         ev_wait_abort,
  output logic         ev_grant_exit
);
  hold_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d       = state_q;
    cnt_load      = 1'b0;
    cnt_val       = '0;
    cnt_dec       = 1'b0;
    ev_wait_abort = 1'b0;
    ev_grant_exit = 1'b0;
    case (state_q)
      HS_IDLE: begin
        if (req && !req_disable) begin
          state_d  = HS_WAIT_DONE;
          cnt_load = 1'b1;
          cnt_val  = W'(FLOAT_EXTRA);
        end
      end
      HS_WAIT_DONE: begin
        if (!req) begin
          state_d       = HS_IDLE;
          ev_wait_abort = 1'b1;
        end else if (cnt_zero && !xfer_busy) begin
          state_d  = HS_FLOAT;
          cnt_load = 1'b1;
          cnt_val  = W'(ACK_LEN - 1);
        end else begin
          cnt_dec = 1'b1;
        end
      end
      HS_FLOAT: begin
        if (cnt_zero) state_d = HS_GRANTED;
        else          cnt_dec = 1'b1;
      end
      HS_GRANTED: begin
        if (!req) begin
          state_d       = HS_REDRIVE;
          ev_grant_exit = 1'b1;
          cnt_load      = 1'b1;
          cnt_val       = W'(REDRIVE_LEN - 1);
        end
      end
      HS_REDRIVE: begin
        if (cnt_zero) begin
          state_d  = HS_RELEASE;
          cnt_load = 1'b1;
          cnt_val  = W'(ACK_LEN - 1);
        end else begin
          cnt_dec = 1'b1;
        end
      end
      HS_RELEASE: begin
        if (cnt_zero) state_d = HS_IDLE;
        else          cnt_dec = 1'b1;
      end
      default: state_d = HS_IDLE;
    endcase
  end

  assign state = state_q;
endmodule

// File: rtl/hold_viol_det.sv
module hold_viol_det #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_granted,
  input  logic grant_exit,
  input  logic wait_abort,
  output logic early_rel
);
  localparam int AGE_W = $clog2(LIMIT + 1);

  logic [AGE_W-1:0] age_q;
  logic             short_grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         age_q <= '0;
    else if (!in_granted)               age_q <= '0;
    else if (age_q != AGE_W'(LIMIT))    age_q <= age_q + 1'b1;
  end

  assign short_grant = grant_exit && (age_q < AGE_W'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) early_rel <= 1'b0;
    else        early_rel <= wait_abort | short_grant;
  end
endmodule

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl
  import hold_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_FLOAT_CYC = 2,
  parameter int REDRIVE_CYC   = 4,
  parameter int ACK_LAG       = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req_n,
  input  logic hold_disable,
  input  logic xfer_busy,
  output logic hold_ack_n,
  output logic bus_oe,
  output logic grant_block,
  output logic early_rel
);
  localparam int FLOAT_EXTRA = float_extra(MIN_FLOAT_CYC, SYNC_STAGES);
  localparam int REDRIVE_LEN = redrive_span(REDRIVE_CYC, SYNC_STAGES);
  localparam int ACK_LEN     = ack_span(ACK_LAG);
  localparam int CNT_MAX     = max3(FLOAT_EXTRA, REDRIVE_LEN, ACK_LEN);
  localparam int CNT_W       = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX + 1);
  localparam int GRANT_MIN   = SYNC_STAGES + 1;

  // Named internal events, also observed by the bound checker.
  logic              req_sync;
  logic              cnt_zero, cnt_load, cnt_dec;
  logic [CNT_W-1:0]  cnt_val;
  logic              ev_wait_abort, ev_grant_exit;
  hold_state_e       state;

  hold_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_n_async (hold_req_n),
    .req_o       (req_sync)
  );

  hold_dly_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .dec      (cnt_dec),
    .zero     (cnt_zero)
  );

  hold_fsm #(
    .W           (CNT_W),
    .FLOAT_EXTRA (FLOAT_EXTRA),
    .REDRIVE_LEN (REDRIVE_LEN),
    .ACK_LEN     (ACK_LEN)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req           (req_sync),
    .req_disable   (hold_disable),
    .xfer_busy     (xfer_busy),
    .cnt_zero      (cnt_zero),
    .state         (state),
    .cnt_load      (cnt_load),
    .cnt_val       (cnt_val),
    .cnt_dec       (cnt_dec),
    .ev_wait_abort (ev_wait_abort),
    .ev_grant_exit (ev_grant_exit)
  );

  hold_viol_det #(.LIMIT(GRANT_MIN)) u_viol (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_granted (state == HS_GRANTED),
    .grant_exit (ev_grant_exit),
    .wait_abort (ev_wait_abort),
    .early_rel  (early_rel)
  );

  assign bus_oe      = drives_bus(state);
  assign hold_ack_n  = ~ack_active(state);
  assign grant_block = (state != HS_IDLE);
endmodule

// File: rtl/hold_ctrl_chk.sv
module hold_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic hold_req_n,
  input logic hold_disable,
  input logic xfer_busy,
  input logic hold_ack_n,
  input logic bus_oe,
  input logic grant_block,
  input logic early_rel,
  input logic ev_wait_abort
);
  // Cycles since the request pin was last seen low (saturating).
  logic [3:0] rel_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rel_cnt <= '0;
    else if (!hold_req_n)  rel_cnt <= '0;
    else if (rel_cnt != 4'hF) rel_cnt <= rel_cnt + 1'b1;
  end

  p_float_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |-> (!$past(hold_req_n, 1) && !$past(hold_req_n, 2)));

  p_float_after_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |-> !$past(xfer_busy));

  p_ack_after_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> (!bus_oe && !$past(bus_oe)));

  p_block_when_floated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe || !hold_ack_n) |-> grant_block);

  p_redrive_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> (rel_cnt >= 4'd2 && rel_cnt <= 4'd7));

  p_ack_after_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack_n) |-> (bus_oe && $past(bus_oe)));

  p_disable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_block) |-> !$past(hold_disable));

  p_viol_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    early_rel |=> !early_rel);

  p_abort_keeps_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wait_abort |-> bus_oe);
endmodule

bind bus_hold_ctrl hold_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .hold_req_n    (hold_req_n),
  .hold_disable  (hold_disable),
  .xfer_busy     (xfer_busy),
  .hold_ack_n    (hold_ack_n),
  .bus_oe        (bus_oe),
  .grant_block   (grant_block),
  .early_rel     (early_rel),
  .ev_wait_abort (ev_wait_abort)
);

// File: tb/tb_bus_hold_ctrl.sv
`timescale 1ns/1ps
module tb_bus_hold_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, hold_req_n, hold_disable, xfer_busy;
  logic hold_ack_n, bus_oe, grant_block, early_rel;

  bus_hold_ctrl dut (
    .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n), .hold_disable(hold_disable),
    .xfer_busy(xfer_busy), .hold_ack_n(hold_ack_n), .bus_oe(bus_oe),
    .grant_block(grant_block), .early_rel(early_rel)
  );

  // Event kinds, in the order the monitor scans them within one cycle.
  localparam int K_OE_FALL = 0, K_ACK_FALL = 1, K_OE_RISE = 2, K_ACK_RISE = 3,
                 K_GB_RISE = 4, K_GB_FALL = 5, K_VIOL = 6;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 0, mon_on = 0;
  int    q_kind[$];
  int    q_cyc[$];
  string q_tag[$];
  logic  p_oe, p_ack, p_gb;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_ev(input int k, input int c, input string tag);
    q_kind.push_back(k);
    q_cyc.push_back(c);
    q_tag.push_back(tag);
  endtask

  task automatic got(input int k);
    int ek, ec;
    string et;
    n_chk++;
    if (q_kind.size() == 0) begin
      n_fail++;
      $display("FAIL SB unexpected event act kind=%0d cyc=%0d exp=none", k, cyc);
    end else begin
      ek = q_kind.pop_front();
      ec = q_cyc.pop_front();
      et = q_tag.pop_front();
      if (ek != k || ec != cyc) begin
        n_fail++;
        $display("FAIL %s event act kind=%0d cyc=%0d exp kind=%0d cyc=%0d",
                 et, k, cyc, ek, ec);
      end
    end
  endtask

  // Monitor: turns output edges into events and compares with the queue.
  always @(negedge clk) begin
    if (mon_on) begin
      if (p_oe && !bus_oe)        got(K_OE_FALL);
      if (p_ack && !hold_ack_n)   got(K_ACK_FALL);
      if (!p_oe && bus_oe)        got(K_OE_RISE);
      if (!p_ack && hold_ack_n)   got(K_ACK_RISE);
      if (!p_gb && grant_block)   got(K_GB_RISE);
      if (p_gb && !grant_block)   got(K_GB_FALL);
      if (early_rel)              got(K_VIOL);
      p_oe  = bus_oe;
      p_ack = hold_ack_n;
      p_gb  = grant_block;
    end
  end

  task automatic at_cycle(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Standard grant expectations for a request driven in cycle c, no busy.
  task automatic expect_grant(input int c, input string tag);
    expect_ev(K_GB_RISE,  c + 3, "R5");
    expect_ev(K_OE_FALL,  c + 4, tag);
    expect_ev(K_ACK_FALL, c + 5, "R4");
  endtask

  task automatic expect_release(input int r, input bit viol);
    if (viol) expect_ev(K_VIOL, r + 3, "R9");
    expect_ev(K_OE_RISE,  r + 5, "R6");
    expect_ev(K_ACK_RISE, r + 6, "R6");
    expect_ev(K_GB_FALL,  r + 6, "R5");
  endtask

  int c, r, b, d;

  initial begin
    rst_n = 1'b0; hold_req_n = 1'b1; hold_disable = 1'b0; xfer_busy = 1'b0;
    repeat (3) @(negedge clk);
    check(bus_oe == 1'b1 && hold_ack_n == 1'b1, "R1", "reset oe/ack", {bus_oe, hold_ack_n}, 3);
    check(grant_block == 1'b0 && early_rel == 1'b0, "R1", "reset gb/viol", {grant_block, early_rel}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    p_oe = bus_oe; p_ack = hold_ack_n; p_gb = grant_block;
    mon_on = 1;
    check(bus_oe == 1'b1 && hold_ack_n == 1'b1 && grant_block == 1'b0, "R1",
          "after reset", {bus_oe, hold_ack_n, grant_block}, 6);

    // A: plain grant and late release (R2, R4, R5, R6, R10)
    c = cyc; hold_req_n = 1'b0; expect_grant(c, "R2");
    at_cycle(c + 3); check(bus_oe == 1'b1, "R2", "bus not yet floated", bus_oe, 1);
    at_cycle(c + 12); r = cyc; hold_req_n = 1'b1; expect_release(r, 0);
    at_cycle(r + 4); check(grant_block == 1'b1, "R5", "block during redrive", grant_block, 1);
    check(bus_oe == 1'b0, "R6", "bus still floated before E1+4", bus_oe, 0);
    at_cycle(r + 12);

    // B: transfer starts in the cycle the request is accepted (R3, R5)
    c = cyc; hold_req_n = 1'b0;
    expect_ev(K_GB_RISE, c + 3, "R5");
    at_cycle(c + 2); xfer_busy = 1'b1;
    at_cycle(c + 6); check(bus_oe == 1'b1, "R3", "no float while busy", bus_oe, 1);
    check(grant_block == 1'b1, "R5", "block while waiting", grant_block, 1);
    at_cycle(c + 9); b = cyc; xfer_busy = 1'b0;
    expect_ev(K_OE_FALL, b + 1, "R3");
    expect_ev(K_ACK_FALL, b + 2, "R4");
    at_cycle(b + 8); r = cyc; hold_req_n = 1'b1; expect_release(r, 0);
    at_cycle(r + 12);

    // C: disable holds off the request, clearing it starts the grant (R7, R8)
    hold_disable = 1'b1;
    @(negedge clk);
    c = cyc; hold_req_n = 1'b0;
    at_cycle(c + 20);
    check(bus_oe == 1'b1, "R7", "bus kept while disabled", bus_oe, 1);
    check(hold_ack_n == 1'b1, "R7", "no ack while disabled", hold_ack_n, 1);
    check(grant_block == 1'b0, "R7", "no block while disabled", grant_block, 0);
    d = cyc; hold_disable = 1'b0;
    expect_ev(K_GB_RISE,  d + 1, "R8");
    expect_ev(K_OE_FALL,  d + 2, "R8");
    expect_ev(K_ACK_FALL, d + 3, "R8");
    at_cycle(d + 10); r = cyc; hold_req_n = 1'b1; expect_release(r, 0);
    at_cycle(r + 12);

    // D: withdrawal in the acknowledge cycle (R9)
    c = cyc; hold_req_n = 1'b0; expect_grant(c, "R2");
    at_cycle(c + 5); r = cyc; hold_req_n = 1'b1; expect_release(r, 1);
    at_cycle(r + 12);

    // F: withdrawal one cycle later, boundary without violation (R10)
    c = cyc; hold_req_n = 1'b0; expect_grant(c, "R2");
    at_cycle(c + 6); r = cyc; hold_req_n = 1'b1; expect_release(r, 0);
    at_cycle(r + 3); check(early_rel == 1'b0, "R10", "no pulse on legal release", early_rel, 0);
    at_cycle(r + 12);

    // E: withdrawal while a transfer is pending (R9)
    xfer_busy = 1'b1;
    @(negedge clk);
    c = cyc; hold_req_n = 1'b0;
    expect_ev(K_GB_RISE, c + 3, "R5");
    expect_ev(K_GB_FALL, c + 4, "R9");
    expect_ev(K_VIOL,    c + 4, "R9");
    at_cycle(c + 1); hold_req_n = 1'b1;
    at_cycle(c + 6); check(bus_oe == 1'b1, "R9", "aborted grant never floats", bus_oe, 1);
    xfer_busy = 1'b0;
    at_cycle(c + 12);

    check(q_kind.size() == 0, "SB", "events left in queue", q_kind.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL WATCHDOG act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule